// File: doc/BRIEF.md
# Dual-Order Wrapping Burst Address Generator

This block produces the two least significant address bits for a four-beat cache line burst. When an access opens, a load strobe captures the starting pair of bits; each later clock edge that sees the active-low step input low moves to the next beat. A step input held high freezes the current beat, which suspends the burst. Successive beats always stay inside the aligned group of four that holds the start address.

A strap input picks the visiting order. Low selects linear order: the start value plus the beat number, modulo four. High selects interleaved order: the start value XOR the beat number. The strap is wired once at integration and does not change while the block runs. A flag output marks the fourth beat of the group, so a controller can see where the burst ends.

Internally the block keeps the captured start bits and a beat number that counts from zero. The output address comes from these two registers through a small order-mapping stage. Reset is asserted asynchronously and released synchronously to the clock.

Top module: `burst_seq_gen`

## Requirements
- R1: While reset is asserted, and on the first cycles after it is released, `addr_o` is 00 and `last_o` is 0.
- R2: A clock edge that samples `load_i` high captures `start_i`, so after that edge `addr_o` equals the loaded start bits and `last_o` is 0.
- R3: A clock edge that samples `load_i` low and `adv_n_i` low moves the burst forward by exactly one beat.
- R4: A clock edge that samples `load_i` low and `adv_n_i` high leaves `addr_o` and `last_o` unchanged.
- R5: With `mode_i` = 0 (linear), the order is the start plus the beat number modulo four. From 00: 00,01,10,11. From 01: 01,10,11,00. From 10: 10,11,00,01. From 11: 11,00,01,10.
- R6: With `mode_i` = 1 (interleaved), the order is the start XOR the beat number. From 00: 00,01,10,11. From 01: 01,00,11,10. From 10: 10,11,00,01. From 11: 11,10,01,00.
- R7: A fifth step after the fourth beat wraps `addr_o` back to the start bits, so no beat leaves the aligned group of four.
- R8: When `load_i` and `adv_n_i` = 0 are sampled on the same edge, the load wins: `addr_o` becomes the new start bits and the beat number restarts at zero.
- R9: `last_o` is 1 exactly when the burst is on its fourth beat (beat number 3), in either order.
- R10: `mode_i` is a static strap and holds its value for the whole time the block is out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_i | input | 1 | Starts a burst and captures `start_i` |
| start_i | input | 2 | Starting low address bits of the burst |
| adv_n_i | input | 1 | Active-low step request |
| mode_i | input | 1 | Order strap: 0 linear, 1 interleaved |
| addr_o | output | 2 | Current low address bits of the burst |
| last_o | output | 1 | High on the fourth beat of the group |

## Verification
The assertions assume that the order strap never changes once the block is out of reset. A dedicated check flags any violation of that assumption. The stimulus changes `mode_i` only during a reset pulse, and each order gets its own phase between resets. The assertions also assume that inputs are settled at each edge, so the bench drives them one nanosecond after a rising edge. Load and step requests may come in any combination, including both on the same edge, and the stimulus exercises every such combination.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int unsigned BEAT_W = 2;
  localparam int unsigned BEATS  = 1 << BEAT_W;

  typedef logic [BEAT_W-1:0] beat_t;

  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/burst_rst_sync.sv
module burst_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_i,
  input  beat_t start_i,
  input  logic  adv_n_i,
  output beat_t start_o,
  output beat_t beat_o,
  output logic  last_o
);
  beat_t start_q, start_d;
  beat_t beat_q, beat_d;
  logic  start_en, beat_en;

  // Load wins over a step on the same edge.
  always_comb begin
    start_en = load_i;
    start_d  = start_i;
    beat_en  = load_i | ~adv_n_i;
    beat_d   = load_i ? beat_t'(0) : beat_t'(beat_q + beat_t'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      beat_q  <= '0;
    end else begin
      if (start_en) start_q <= start_d;
      if (beat_en)  beat_q  <= beat_d;
    end
  end

  assign start_o = start_q;
  assign beat_o  = beat_q;
  assign last_o  = (beat_q == beat_t'(BEATS-1));

  // R2
  load_clears_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (beat_o == '0 && start_o == $past(start_i)));
  // R3
  step_one_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_n_i) |=> (beat_o == beat_t'($past(beat_o) + beat_t'(1))));
  // R4
  hold_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && adv_n_i) |=> ($stable(beat_o) && $stable(start_o)));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
(
  input  order_e order_i,
  input  beat_t  start_i,
  input  beat_t  beat_i,
  output beat_t  addr_o
);
  beat_t lin_addr, ilv_addr;

  always_comb begin
    lin_addr = beat_t'(start_i + beat_i);
    ilv_addr = start_i ^ beat_i;
    addr_o   = (order_i == ORDER_INTERLEAVE) ? ilv_addr : lin_addr;
  end

  // R5 R6: the first beat is always the start value in both orders
  always_comb begin
    if (beat_i == '0) first_beat_is_start_chk: assert (addr_o == start_i);
  end
endmodule

// File: rtl/burst_seq_gen.sv
module burst_seq_gen
  import burst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [1:0] start_i,
  input  logic       adv_n_i,
  input  logic       mode_i,
  output logic [1:0] addr_o,
  output logic       last_o
);
  logic   rst_n_s;
  beat_t  start_w, beat_w;
  order_e order_w;

  assign order_w = order_e'(mode_i);

  burst_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_s)
  );

  burst_beat_ctr ctr_i (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .load_i  (load_i),
    .start_i (start_i),
    .adv_n_i (adv_n_i),
    .start_o (start_w),
    .beat_o  (beat_w),
    .last_o  (last_o)
  );

  burst_order_map map_i (
    .order_i (order_w),
    .start_i (start_w),
    .beat_i  (beat_w),
    .addr_o  (addr_o)
  );

  // R10
  mode_static_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $stable(mode_i));
  // R8
  load_priority_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (load_i && !adv_n_i) |=> (addr_o == $past(start_i) && !last_o));
  // R7
  wrap_to_start_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!load_i && !adv_n_i && last_o) |=> (addr_o == start_w && !last_o));
  // R4
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!load_i && adv_n_i) |=> ($stable(addr_o) && $stable(last_o)));
endmodule

// File: tb/burst_seq_gen_tb_top.sv
`timescale 1ns/1ps
module burst_seq_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       load_i;
  logic [1:0] start_i;
  logic       adv_n_i;
  logic       mode_i;
  logic [1:0] addr_o;
  logic       last_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  burst_seq_gen dut_i (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_i(start_i),
    .adv_n_i(adv_n_i), .mode_i(mode_i), .addr_o(addr_o), .last_o(last_o)
  );

  function automatic logic [1:0] exp_addr(input logic m, input logic [1:0] s,
                                          input logic [1:0] b);
    return m ? (s ^ b) : 2'(s + b);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_reset(input logic m);
    rst_n = 1'b0; load_i = 1'b0; adv_n_i = 1'b1; start_i = 2'b00; mode_i = m;
    tick(); tick();
    chk("R1 addr in reset", addr_o, 0);
    chk("R1 last in reset", last_o, 0);
    rst_n = 1'b1;
    tick(); tick(); tick();
    chk("R1 addr after release", addr_o, 0);
    chk("R1 last after release", last_o, 0);
  endtask

  // R2 R3 R5 R6 R7 R9: full burst with a wrap step
  task automatic t_burst(input logic m, input logic [1:0] s);
    load_i = 1'b1; start_i = s; adv_n_i = 1'b1;
    tick();
    load_i = 1'b0;
    chk("R2 load start", addr_o, s);
    chk("R9 last on beat 0", last_o, 0);
    for (int b = 1; b < 4; b++) begin
      adv_n_i = 1'b0;
      tick();
      chk(m ? "R6 interleaved beat" : "R5 linear beat", addr_o, exp_addr(m, s, 2'(b)));
      chk("R9 last flag", last_o, (b == 3) ? 1 : 0);
    end
    tick();
    adv_n_i = 1'b1;
    chk("R7 wrap to start", addr_o, s);
    chk("R7 last cleared on wrap", last_o, 0);
  endtask

  // R4: suspend mid-burst
  task automatic t_hold(input logic m);
    load_i = 1'b1; start_i = 2'b10; adv_n_i = 1'b1;
    tick();
    load_i = 1'b0; adv_n_i = 1'b0;
    tick();
    adv_n_i = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R4 hold addr", addr_o, exp_addr(m, 2'b10, 2'b01));
      chk("R4 hold last", last_o, 0);
    end
    adv_n_i = 1'b0;
    tick();
    adv_n_i = 1'b1;
    chk("R3 resume step", addr_o, exp_addr(m, 2'b10, 2'b10));
  endtask

  // R8: load and advance together
  task automatic t_priority(input logic m);
    load_i = 1'b1; start_i = 2'b01; adv_n_i = 1'b1;
    tick();
    load_i = 1'b0; adv_n_i = 1'b0;
    tick(); tick();
    load_i = 1'b1; start_i = 2'b11; adv_n_i = 1'b0;
    tick();
    load_i = 1'b0;
    chk("R8 load wins addr", addr_o, 3);
    chk("R8 load wins last", last_o, 0);
    tick();
    adv_n_i = 1'b1;
    chk("R8 beat restarted", addr_o, exp_addr(m, 2'b11, 2'b01));
  endtask

  initial begin
    do_reset(1'b0);
    for (int s = 0; s < 4; s++) t_burst(1'b0, 2'(s));
    t_hold(1'b0);
    t_priority(1'b0);
    do_reset(1'b1);
    for (int s = 0; s < 4; s++) t_burst(1'b1, 2'(s));
    t_hold(1'b1);
    t_priority(1'b1);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule